// File: doc/BRIEF.md
# Sound Bus Address Decoder with Address-Written Filter Register

This block sits on the 16-bit address bus of an 8-bit sound processor and turns each bus cycle into one device select. The devices are the program ROM, one or two 1 KB work RAMs, and the data port and register-index port of each of two programmable sound generators. One parameter picks one of two board memory maps. The maps differ in whether the second RAM exists and where the filter window lies.

A write anywhere inside the filter window stores the low twelve address bits into a filter register. The data bus plays no part in this, so the block has no data input. The register is cut into six 2-bit codes, three for each sound generator. Each code switches the capacitors of one analog low-pass stage outside the block. Code bit 0 switches in the larger capacitor and code bit 1 switches in the smaller one. A read of a write-only index port is flagged so that the bus returns all ones.

Top module: `sound_bus_decoder`

## Requirements
- R1: `rom_sel` is high for a read (`bus_rd`=1, `bus_wr`=0) at an address in 0x0000–0x1FFF, and never for a write.
- R2: `ram0_sel` is high for a read or a write at an address in 0x2000–0x23FF. No select is high at 0x2400–0x2FFF.
- R3: With `MAP_SEL`=0, `ram1_sel` is high for a read or a write at 0x3000–0x33FF. With `MAP_SEL`=1, `ram1_sel` is never high.
- R4: `gen0_data_sel` is high for a read or a write at exactly 0x4000. `gen1_data_sel` is high for a read or a write at exactly 0x6000. Neighbouring addresses select nothing.
- R5: `gen0_idx_sel` (exactly 0x5000) and `gen1_idx_sel` (exactly 0x7000) are high only for writes. A read at either address raises `fill_en`, with `fill_data`=0xFF. When `fill_en` is low, `fill_data` is 0x00.
- R6: A write in the filter window loads `bus_addr[11:0]` into the filter register on the next rising clock edge. The window is 0x8000–0x8FFF when `MAP_SEL`=0 and 0x3000–0x3FFF when `MAP_SEL`=1. A read in the window, or a write outside it, leaves the register unchanged.
- R7: The filter codes are taken from the register as follows:
  - `gen1_flt0`, `gen1_flt1`, `gen1_flt2` are bits [1:0], [3:2] and [5:4].
  - `gen0_flt0`, `gen0_flt1`, `gen0_flt2` are bits [7:6], [9:8] and [11:10].
  - In each code, bit 0 enables the larger capacitor and bit 1 enables the smaller one.
- R8: A synchronous reset (`rst_n`=0 at a rising edge) clears all six filter codes to 0, meaning no capacitor is switched in.
- R9: A cycle with both `bus_rd` and `bus_wr` high, or with both low, raises no select, no `fill_en`, no strobe and no filter load. At most one select is high at any time.
- R10: `dev_rd` is high exactly when a read raises a select or `fill_en`. `dev_wr` is high exactly when a write raises a select or hits the filter window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Processor address |
| bus_rd | input | 1 | Read cycle |
| bus_wr | input | 1 | Write cycle |
| rom_sel | output | 1 | Program ROM select |
| ram0_sel | output | 1 | Work RAM select |
| ram1_sel | output | 1 | Second RAM select (primary map only) |
| gen0_data_sel | output | 1 | Generator 0 data port select |
| gen0_idx_sel | output | 1 | Generator 0 register-index write select |
| gen1_data_sel | output | 1 | Generator 1 data port select |
| gen1_idx_sel | output | 1 | Generator 1 register-index write select |
| dev_rd | output | 1 | Decoded read strobe |
| dev_wr | output | 1 | Decoded write strobe |
| fill_en | output | 1 | Bus must return the fill value |
| fill_data | output | 8 | Fill value |
| gen0_flt0 | output | 2 | Generator 0 channel 0 filter code |
| gen0_flt1 | output | 2 | Generator 0 channel 1 filter code |
| gen0_flt2 | output | 2 | Generator 0 channel 2 filter code |
| gen1_flt0 | output | 2 | Generator 1 channel 0 filter code |
| gen1_flt1 | output | 2 | Generator 1 channel 1 filter code |
| gen1_flt2 | output | 2 | Generator 1 channel 2 filter code |

## Verification
On every cycle, the assertions check the following:
- at most one select is high;
- the ROM select and the index-port selects follow the read or write direction;
- the second RAM stays absent in the alternate map;
- `fill_en` is tied to reads;
- the filter register loads on a filter write and holds on every other cycle.

The exact address boundaries of each region are shown only by the bench's scenarios. So is the placement of the window in each map, and so are the bit fields of the six codes. The bench sweeps every address under every read and write combination for both maps, and runs directed filter writes.

// File: rtl/sbd_pkg.sv
// Package: shared region codes and the fixed address layout of the sound bus.
// Assumes a 16-bit address; region bases are compared on their upper bits.
package sbd_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int FLT_W    = 12;
    localparam int CODE_W   = 2;
    localparam int N_CODES  = FLT_W / CODE_W;

    // Map variants selected by the top-level parameter.
    localparam int MAP_PRIMARY   = 0;
    localparam int MAP_ALTERNATE = 1;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_ROM,
        RG_RAM0,
        RG_RAM1,
        RG_G0_DATA,
        RG_G0_IDX,
        RG_G1_DATA,
        RG_G1_IDX,
        RG_FILTER
    } region_e;

    // Select vector, one bit per device.
    typedef struct packed {
        logic rom;
        logic ram0;
        logic ram1;
        logic g0_data;
        logic g0_idx;
        logic g1_data;
        logic g1_idx;
    } sel_t;

    // Region geometry: the upper-bit prefix and the number of low bits it spans.
    localparam int ROM_SPAN   = 13;   // 8 KB
    localparam int RAM_SPAN   = 10;   // 1 KB
    localparam int WIN_SPAN   = 12;   // 4 KB filter window
    localparam logic [ADDR_W-1:0] ROM_BASE   = 16'h0000;
    localparam logic [ADDR_W-1:0] RAM0_BASE  = 16'h2000;
    localparam logic [ADDR_W-1:0] RAM1_BASE  = 16'h3000;
    localparam logic [ADDR_W-1:0] G0_DATA_AD = 16'h4000;
    localparam logic [ADDR_W-1:0] G0_IDX_AD  = 16'h5000;
    localparam logic [ADDR_W-1:0] G1_DATA_AD = 16'h6000;
    localparam logic [ADDR_W-1:0] G1_IDX_AD  = 16'h7000;
    localparam logic [ADDR_W-1:0] WIN_PRI    = 16'h8000;
    localparam logic [ADDR_W-1:0] WIN_ALT    = 16'h3000;

    localparam logic [DATA_W-1:0] FILL_VALUE = '1;

endpackage

// File: rtl/sbd_region_match.sv
// Module: sbd_region_match
// Purely combinational. Maps an address onto one region of the chosen board map.
// Assumes the region list is non-overlapping within each map variant.
module sbd_region_match
    import sbd_pkg::*;
#(
    parameter int MAP_SEL = MAP_PRIMARY
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    logic hit_rom, hit_ram0, hit_ram1, hit_win;
    logic hit_g0d, hit_g0i, hit_g1d, hit_g1i;

    // Purpose: compare the upper address bits against the fixed regions.
    always_comb begin
        hit_rom  = addr[ADDR_W-1:ROM_SPAN] == ROM_BASE[ADDR_W-1:ROM_SPAN];
        hit_ram0 = addr[ADDR_W-1:RAM_SPAN] == RAM0_BASE[ADDR_W-1:RAM_SPAN];
        hit_g0d  = addr == G0_DATA_AD;
        hit_g0i  = addr == G0_IDX_AD;
        hit_g1d  = addr == G1_DATA_AD;
        hit_g1i  = addr == G1_IDX_AD;
    end

    generate
        if (MAP_SEL == MAP_PRIMARY) begin : g_primary
            // Purpose: the primary map has a second RAM and a high filter window.
            always_comb begin
                hit_ram1 = addr[ADDR_W-1:RAM_SPAN] == RAM1_BASE[ADDR_W-1:RAM_SPAN];
                hit_win  = addr[ADDR_W-1:WIN_SPAN] == WIN_PRI[ADDR_W-1:WIN_SPAN];
            end
        end else begin : g_alternate
            // Purpose: the alternate map has no second RAM; its window sits in its place.
            always_comb begin
                hit_ram1 = 1'b0;
                hit_win  = addr[ADDR_W-1:WIN_SPAN] == WIN_ALT[ADDR_W-1:WIN_SPAN];
            end
        end
    endgenerate

    // Purpose: encode the single matching region.
    always_comb begin
        region = RG_NONE;
        if (hit_rom)       region = RG_ROM;
        else if (hit_ram0) region = RG_RAM0;
        else if (hit_ram1) region = RG_RAM1;
        else if (hit_g0d)  region = RG_G0_DATA;
        else if (hit_g0i)  region = RG_G0_IDX;
        else if (hit_g1d)  region = RG_G1_DATA;
        else if (hit_g1i)  region = RG_G1_IDX;
        else if (hit_win)  region = RG_FILTER;
    end

endmodule

// File: rtl/sbd_strobe_gen.sv
// Module: sbd_strobe_gen
// Combinational. Qualifies the region with the cycle direction and produces the
// selects, the decoded strobes, the fill request and the filter write enable.
// Assumes a cycle with both or neither direction set is not a bus access.
module sbd_strobe_gen
    import sbd_pkg::*;
(
    input  region_e           region,
    input  logic              rd,
    input  logic              wr,
    output sel_t              sel,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic              fill_en,
    output logic [DATA_W-1:0] fill_data,
    output logic              flt_we
);

    logic rd_q, wr_q, any_q;

    // Purpose: reduce the two direction inputs to one valid direction.
    always_comb begin
        rd_q  = rd & ~wr;
        wr_q  = wr & ~rd;
        any_q = rd_q | wr_q;
    end

    // Purpose: gate each region with the directions it accepts.
    always_comb begin
        sel.rom     = rd_q  & (region == RG_ROM);
        sel.ram0    = any_q & (region == RG_RAM0);
        sel.ram1    = any_q & (region == RG_RAM1);
        sel.g0_data = any_q & (region == RG_G0_DATA);
        sel.g0_idx  = wr_q  & (region == RG_G0_IDX);
        sel.g1_data = any_q & (region == RG_G1_DATA);
        sel.g1_idx  = wr_q  & (region == RG_G1_IDX);
        flt_we      = wr_q  & (region == RG_FILTER);
        fill_en     = rd_q  & ((region == RG_G0_IDX) | (region == RG_G1_IDX));
    end

    // Purpose: drive the fill value only while a fill is requested.
    always_comb begin
        fill_data = fill_en ? FILL_VALUE : '0;
    end

    // Purpose: form the decoded strobes from the qualified selects.
    always_comb begin
        dev_rd = rd_q & (sel.rom | sel.ram0 | sel.ram1 | sel.g0_data | sel.g1_data | fill_en);
        dev_wr = wr_q & (sel.ram0 | sel.ram1 | sel.g0_data | sel.g1_data
                         | sel.g0_idx | sel.g1_idx | flt_we);
    end

endmodule

// File: rtl/sbd_filter_reg.sv
// Module: sbd_filter_reg
// Holds the filter word that is written through the address lines and splits it
// into equal-width codes. Assumes the write enable is already qualified.
module sbd_filter_reg
    import sbd_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [FLT_W-1:0]                din,
    output logic [FLT_W-1:0]                word,
    output logic [N_CODES-1:0][CODE_W-1:0]  codes
);

    // Purpose: capture the address slice on a window write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  word <= '0;
        else if (we) word <= din;
    end

    generate
        for (genvar i = 0; i < N_CODES; i++) begin : g_slice
            // Purpose: cut code i from its fixed bit pair.
            always_comb codes[i] = word[i*CODE_W +: CODE_W];
        end
    endgenerate

endmodule

// File: rtl/sound_bus_decoder.sv
// Module: sound_bus_decoder (top)
// Decodes the sound-processor bus for one of two board maps and keeps the
// address-written filter register. Assumes bus_rd and bus_wr are sampled
// synchronously to clk for the filter write, and are level-valid for the selects.
module sound_bus_decoder
    import sbd_pkg::*;
#(
    parameter int MAP_SEL = MAP_PRIMARY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              rom_sel,
    output logic              ram0_sel,
    output logic              ram1_sel,
    output logic              gen0_data_sel,
    output logic              gen0_idx_sel,
    output logic              gen1_data_sel,
    output logic              gen1_idx_sel,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic              fill_en,
    output logic [7:0]        fill_data,
    output logic [1:0]        gen0_flt0,
    output logic [1:0]        gen0_flt1,
    output logic [1:0]        gen0_flt2,
    output logic [1:0]        gen1_flt0,
    output logic [1:0]        gen1_flt1,
    output logic [1:0]        gen1_flt2
);

    localparam int G1_FIRST = 0;            // generator 1 codes occupy the low pairs
    localparam int G0_FIRST = N_CODES / 2;  // generator 0 codes occupy the high pairs

    region_e                           region;
    sel_t                              sel;
    logic                              flt_we;
    logic [FLT_W-1:0]                  flt_word;
    logic [N_CODES-1:0][CODE_W-1:0]    codes;

    sbd_region_match #(.MAP_SEL(MAP_SEL)) u_match (
        .addr   (bus_addr),
        .region (region)
    );

    sbd_strobe_gen u_strobe (
        .region    (region),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .sel       (sel),
        .dev_rd    (dev_rd),
        .dev_wr    (dev_wr),
        .fill_en   (fill_en),
        .fill_data (fill_data),
        .flt_we    (flt_we)
    );

    sbd_filter_reg u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flt_we),
        .din   (bus_addr[FLT_W-1:0]),
        .word  (flt_word),
        .codes (codes)
    );

    // Purpose: fan the select struct out to the device pins.
    always_comb begin
        rom_sel       = sel.rom;
        ram0_sel      = sel.ram0;
        ram1_sel      = sel.ram1;
        gen0_data_sel = sel.g0_data;
        gen0_idx_sel  = sel.g0_idx;
        gen1_data_sel = sel.g1_data;
        gen1_idx_sel  = sel.g1_idx;
    end

    // Purpose: route the code pairs to the per-channel filter pins.
    always_comb begin
        gen1_flt0 = codes[G1_FIRST + 0];
        gen1_flt1 = codes[G1_FIRST + 1];
        gen1_flt2 = codes[G1_FIRST + 2];
        gen0_flt0 = codes[G0_FIRST + 0];
        gen0_flt1 = codes[G0_FIRST + 1];
        gen0_flt2 = codes[G0_FIRST + 2];
    end

endmodule

// File: rtl/sbd_checker.sv
// Module: sbd_checker
// Clocked properties for sound_bus_decoder, attached through bind below.
// Assumes it sees the top-level ports plus the filter write enable and word.
module sbd_checker #(
    parameter int MAP_SEL = 0
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        rom_sel,
    input logic        ram0_sel,
    input logic        ram1_sel,
    input logic        gen0_data_sel,
    input logic        gen0_idx_sel,
    input logic        gen1_data_sel,
    input logic        gen1_idx_sel,
    input logic        fill_en,
    input logic        flt_we,
    input logic [11:0] flt_word
);

    logic [6:0] sel_vec;
    always_comb sel_vec = {rom_sel, ram0_sel, ram1_sel, gen0_data_sel,
                           gen0_idx_sel, gen1_data_sel, gen1_idx_sel};

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_vec)); // R9
    AST_ROM_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (bus_rd && !bus_wr)); // R1
    AST_IDX_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (gen0_idx_sel || gen1_idx_sel) |-> (bus_wr && !bus_rd)); // R5
    AST_FILL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> (bus_rd && !bus_wr && !gen0_idx_sel && !gen1_idx_sel)); // R5
    AST_NO_RAM1_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (MAP_SEL != 0) |-> !ram1_sel); // R3
    AST_FLT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        flt_we |=> (flt_word == $past(bus_addr[11:0]))); // R6
    AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_we |=> $stable(flt_word)); // R6
    AST_FLT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        flt_we |-> (bus_wr && !bus_rd)); // R9

endmodule

bind sound_bus_decoder sbd_checker #(.MAP_SEL(MAP_SEL)) u_sbd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .rom_sel       (rom_sel),
    .ram0_sel      (ram0_sel),
    .ram1_sel      (ram1_sel),
    .gen0_data_sel (gen0_data_sel),
    .gen0_idx_sel  (gen0_idx_sel),
    .gen1_data_sel (gen1_data_sel),
    .gen1_idx_sel  (gen1_idx_sel),
    .fill_en       (fill_en),
    .flt_we        (flt_we),
    .flt_word      (flt_word)
);

// File: tb/test_sound_bus_decoder.sv
// Bench for sound_bus_decoder: both map variants side by side, a full address
// sweep under every direction combination, then directed filter writes.
module test_sound_bus_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // Outputs of both instances: index 0 primary, 1 alternate.
    logic [6:0]  sel [2];
    logic        drd [2], dwr [2], fen [2];
    logic [7:0]  fdat [2];
    logic [1:0]  g0f [2][3];
    logic [1:0]  g1f [2][3];

    sound_bus_decoder #(.MAP_SEL(0)) i_sound_bus_decoder (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .rom_sel(sel[0][6]), .ram0_sel(sel[0][5]), .ram1_sel(sel[0][4]),
        .gen0_data_sel(sel[0][3]), .gen0_idx_sel(sel[0][2]),
        .gen1_data_sel(sel[0][1]), .gen1_idx_sel(sel[0][0]),
        .dev_rd(drd[0]), .dev_wr(dwr[0]), .fill_en(fen[0]), .fill_data(fdat[0]),
        .gen0_flt0(g0f[0][0]), .gen0_flt1(g0f[0][1]), .gen0_flt2(g0f[0][2]),
        .gen1_flt0(g1f[0][0]), .gen1_flt1(g1f[0][1]), .gen1_flt2(g1f[0][2]));

    sound_bus_decoder #(.MAP_SEL(1)) i_sound_bus_decoder_alt (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .rom_sel(sel[1][6]), .ram0_sel(sel[1][5]), .ram1_sel(sel[1][4]),
        .gen0_data_sel(sel[1][3]), .gen0_idx_sel(sel[1][2]),
        .gen1_data_sel(sel[1][1]), .gen1_idx_sel(sel[1][0]),
        .dev_rd(drd[1]), .dev_wr(dwr[1]), .fill_en(fen[1]), .fill_data(fdat[1]),
        .gen0_flt0(g0f[1][0]), .gen0_flt1(g0f[1][1]), .gen0_flt2(g0f[1][2]),
        .gen1_flt0(g1f[1][0]), .gen1_flt1(g1f[1][1]), .gen1_flt2(g1f[1][2]));

    // Expected {sel[6:0], dev_rd, dev_wr, fill_en, fill_data} from the requirements.
    function automatic logic [17:0] expect_bus(int map, int a, bit rd, bit wr);
        bit r = rd && !wr;
        bit w = wr && !rd;
        bit acc = r || w;
        bit in_win = (map == 0) ? (a >= 'h8000 && a <= 'h8FFF) : (a >= 'h3000 && a <= 'h3FFF);
        logic [6:0] s;
        bit f;
        s[6] = r && a <= 'h1FFF;                                  // R1
        s[5] = acc && a >= 'h2000 && a <= 'h23FF;                  // R2
        s[4] = acc && map == 0 && a >= 'h3000 && a <= 'h33FF;      // R3
        s[3] = acc && a == 'h4000;                                 // R4
        s[2] = w && a == 'h5000;                                   // R5
        s[1] = acc && a == 'h6000;                                 // R4
        s[0] = w && a == 'h7000;                                   // R5
        f    = r && (a == 'h5000 || a == 'h7000);                  // R5
        return {s, r && ((|s) || f), w && ((|s) || in_win), f, f ? 8'hFF : 8'h00}; // R10
    endfunction

    task automatic check_filter(int m, logic [11:0] exp, string tag);
        logic [11:0] got;
        got = {g0f[m][2], g0f[m][1], g0f[m][0], g1f[m][2], g1f[m][1], g1f[m][0]};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s map%0d filter got=%03h exp=%03h", tag, m, got, exp);
        end
    endtask

    // One synchronous bus write or read: drive at negedge, settle after the edge.
    task automatic bus_cycle(logic [15:0] a, bit rd, bit wr);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    initial begin
        logic [11:0] ep, ea;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check_filter(0, 12'h000, "R8");
        check_filter(1, 12'h000, "R8");

        // Full sweep: R1 R2 R3 R4 R5 R9 R10 on both maps.
        for (int a = 0; a < 65536; a++) begin
            for (int op = 0; op < 4; op++) begin
                bus_addr = a[15:0]; bus_rd = op[0]; bus_wr = op[1];
                #1;
                for (int m = 0; m < 2; m++) begin
                    logic [17:0] got, exp;
                    got = {sel[m], drd[m], dwr[m], fen[m], fdat[m]};
                    exp = expect_bus(m, a, op[0], op[1]);
                    checks++;
                    if (got !== exp) begin
                        errors++;
                        $display("FAIL R1-R5/R9/R10 map%0d addr=%04h rd=%0d wr=%0d got=%05h exp=%05h",
                                 m, a, op[0], op[1], got, exp);
                    end
                end
            end
        end
        bus_rd = 1'b0; bus_wr = 1'b0;

        // Reset again so the sweep's writes do not matter: R8.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check_filter(0, 12'h000, "R8");
        check_filter(1, 12'h000, "R8");
        ep = 12'h000; ea = 12'h000;

        // R6 R7: primary window write, ignored by the alternate map.
        bus_cycle(16'h8ABC, 0, 1); ep = 12'hABC;
        check_filter(0, ep, "R6 R7"); check_filter(1, ea, "R6");
        // R6 R7: alternate window write; primary sees no window there.
        bus_cycle(16'h35E7, 0, 1); ea = 12'h5E7;
        check_filter(0, ep, "R6"); check_filter(1, ea, "R6 R7");
        // R6: reads in a window do not load.
        bus_cycle(16'h8123, 1, 0);
        bus_cycle(16'h3456, 1, 0);
        check_filter(0, ep, "R6 read"); check_filter(1, ea, "R6 read");
        // R6: writes just outside the windows do not load.
        bus_cycle(16'h9FFF, 0, 1);
        bus_cycle(16'h7FFF, 0, 1);
        bus_cycle(16'h4FFF, 0, 1);
        check_filter(0, ep, "R6 outside"); check_filter(1, ea, "R6 outside");
        // R9: both directions high does not load.
        bus_cycle(16'h8321, 1, 1);
        bus_cycle(16'h3321, 1, 1);
        check_filter(0, ep, "R9"); check_filter(1, ea, "R9");
        // R6 boundaries and R7 per-field walk: one code at a time at each level.
        for (int i = 0; i < 6; i++) begin
            for (int v = 1; v < 4; v++) begin
                logic [11:0] w;
                w = 12'(v << (2 * i));
                bus_cycle({4'h8, w}, 0, 1); ep = w;
                bus_cycle({4'h3, w}, 0, 1); ea = w;
                check_filter(0, ep, "R7"); check_filter(1, ea, "R7");
            end
        end
        bus_cycle(16'h8FFF, 0, 1); ep = 12'hFFF;
        bus_cycle(16'h3000, 0, 1); ea = 12'h000;
        check_filter(0, ep, "R6 edge"); check_filter(1, ea, "R6 edge");
        // R8: reset clears a loaded register.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check_filter(0, 12'h000, "R8"); check_filter(1, 12'h000, "R8");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (180000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule